// File: doc/BRIEF.md
# DMA Channel Request Sequencer

This block is the request front end and transfer sequencer of one DMA channel. It picks one of three request sources: an external request pin, an on-chip peripheral request line, or a free-running auto-request. It turns each accepted request into one transfer unit on the bus. The pin passes through a synchronizer. It can be watched as a low or high level, or for a falling or rising edge. A detected edge is held as one pending request until a unit consumes it.

Each unit is one byte, word or longword beat, or a 16-byte unit made of four longword beats. Every beat is a strobe held until the bus acknowledges it, with a size code and the address step for that beat. In cycle-steal mode the bus request is dropped after every unit. In burst mode it is kept while requests continue. A transfer counter counts units down. When it reaches zero the block pulses done and clears its own enable. Channel instances without the sampling field read that field as zero and always behave as low-level sampling.

Top module: `dma_req_seq`

## Requirements
- R1: After reset the control byte reads 0x00 and xfer_stb, bus_req and done are low.
- R2: The control field at bits [7:6] selects pin sampling. 00 means the request is active while the synchronized pin is low. 10 means active while it is high. 01 triggers on a falling edge and 11 on a rising edge.
- R3: In an instance built with HAS_SAMPLE=0, bits [7:6] read back as 00 whatever is written, and the pin is always sampled as low-level active.
- R4: The control field at bits [2:1] selects the source: 00 pin, 01 auto-request (always requesting while enabled), 10 or 11 the peripheral request line. With source 01 or 1x the pin and the sampling field have no effect.
- R5: The control field at bits [5:4] selects the unit size. 00 gives one beat with xfer_size 00 and addr_inc 1. 01 gives xfer_size 01 and addr_inc 2. 10 gives xfer_size 10 and addr_inc 4. 11 gives four beats, each with xfer_size 10 and addr_inc 4.
- R6: With bit [3] at 0 (cycle steal), bus_req falls after every unit and stays low for at least one cycle. A 16-byte unit is never split by a release.
- R7: With bit [3] at 1 (burst), bus_req stays high between units while the request holds. If a level request is withdrawn, the burst ends after the current unit, and the remaining count is kept.
- R8: The counter is loaded through cnt_we and counts one per unit. A 16-byte unit counts as one. When the last unit is acknowledged, done pulses for one cycle, and the enable bit [0] reads 0 from that cycle on.
- R9: In edge modes one edge yields exactly one unit, however long the pin then stays at its new level.
- R10: A pin change reaches the request logic through two synchronizer flops. The first strobe appears after the third rising clock edge following the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte: enable, source, burst, size, sampling |
| cnt_we | input | 1 | Transfer counter load strobe |
| cnt_data | input | CNT_W | Transfer unit count to load |
| req_pin | input | 1 | Asynchronous external request pin |
| periph_req | input | 1 | On-chip peripheral request (level) |
| bus_ack | input | 1 | Bus acknowledge of the current beat |
| xfer_stb | output | 1 | Beat strobe, held until acknowledged |
| xfer_size | output | 2 | Beat size code |
| addr_inc | output | 3 | Address step of the beat in bytes |
| bus_req | output | 1 | Bus ownership request |
| done | output | 1 | One-cycle pulse when the count is exhausted |
| cfg_q | output | 8 | Control byte read-back |

## Verification
A wrong pending-edge latch shows up as extra or missing strobes within a few cycles of the pin edge. A wrong beat counter for the 16-byte unit shows up as a beat total that is not a multiple of four, and as a bus_req drop in the middle of a unit. A wrong transfer counter moves the done pulse and the enable clear by whole units. The bench compares the number of beats, bus releases and done pulses against values derived from the control byte. It also checks synchronizer latency at cycle granularity, and it uses a second instance without the sampling field.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic [1:0] {
    SRC_PIN    = 2'b00,
    SRC_AUTO   = 2'b01,
    SRC_PERIPH = 2'b10,
    SRC_PERIPH2 = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_LONG  = 2'b10,
    SZ_UNIT16 = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_XFER = 2'b01,
    ST_GAP  = 2'b10
  } st_e;

  // Control byte, MSB first: sampling, size, burst, source, enable
  typedef struct packed {
    logic [1:0] smode;
    size_e      size;
    logic       burst;
    src_e       src;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int UNIT16_BEATS = 4;

  function automatic logic [2:0] step_of(size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] beat_code(size_e s);
    return (s == SZ_UNIT16) ? 2'b10 : s;
  endfunction

endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter bit HAS_SAMPLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              clr_en,
  output ctrl_t             ctrl
);

  logic [1:0] smode_in;

  generate
    if (HAS_SAMPLE) begin : g_smp
      assign smode_in = wr_data[CTRL_W-1 -: 2];
    end else begin : g_nosmp
      assign smode_in = 2'b00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else begin
      if (wr_en) ctrl <= ctrl_t'({smode_in, wr_data[CTRL_W-3:0]});
      if (clr_en) ctrl.en <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect
  import dma_req_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  pin,
  input  logic  periph_req,
  input  ctrl_t ctrl,
  input  logic  consume,
  output logic  req
);

  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              pin_s;
  logic              edge_hit;
  logic              level_hit;
  logic              is_edge;
  logic              pend_q;
  logic              pin_req;

  assign pin_s     = sync_q[SYNC_N-1];
  assign is_edge   = ctrl.smode[0];
  assign level_hit = ctrl.smode[1] ? pin_s : ~pin_s;
  assign edge_hit  = ctrl.smode[1] ? (pin_s & ~prev_q) : (~pin_s & prev_q);
  assign pin_req   = is_edge ? (pend_q | edge_hit) : level_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin};
      prev_q <= pin_s;
      if (ctrl.en && is_edge && ctrl.src == SRC_PIN)
        pend_q <= (pend_q | edge_hit) & ~consume;
      else
        pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (ctrl.src)
      SRC_AUTO: req = ctrl.en;
      SRC_PIN:  req = ctrl.en & pin_req;
      default:  req = ctrl.en & periph_req;
    endcase
  end

endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
  import dma_req_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic             req,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_data,
  input  logic             bus_ack,
  output logic             xfer_stb,
  output logic             bus_req,
  output logic [1:0]       xfer_size,
  output logic [2:0]       addr_inc,
  output logic             done,
  output logic             clr_en,
  output logic             consume
);

  localparam int BEAT_W = $clog2(UNIT16_BEATS);

  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic [BEAT_W-1:0] beat;
  size_e            usize;
  logic             last_beat;
  logic             unit_end;
  logic             final_unit;
  logic             go;
  logic             cont;

  assign last_beat  = (usize != SZ_UNIT16) || (beat == BEAT_W'(UNIT16_BEATS - 1));
  assign unit_end   = (st == ST_XFER) && bus_ack && last_beat;
  assign final_unit = unit_end && (cnt == CNT_W'(1));
  assign go         = (st == ST_IDLE) && req && (cnt != '0);
  assign cont       = unit_end && !final_unit && ctrl.burst && req;
  assign consume    = go | cont;
  assign clr_en     = final_unit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      beat      <= '0;
      usize     <= SZ_BYTE;
      xfer_stb  <= 1'b0;
      bus_req   <= 1'b0;
      xfer_size <= 2'b00;
      addr_inc  <= 3'd0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go) begin
            st        <= ST_XFER;
            xfer_stb  <= 1'b1;
            bus_req   <= 1'b1;
            beat      <= '0;
            usize     <= ctrl.size;
            xfer_size <= beat_code(ctrl.size);
            addr_inc  <= step_of(ctrl.size);
          end
        end
        ST_XFER: begin
          if (bus_ack) begin
            if (!last_beat) begin
              beat <= beat + 1'b1;
            end else begin
              cnt  <= cnt - 1'b1;
              beat <= '0;
              if (final_unit) begin
                done     <= 1'b1;
                xfer_stb <= 1'b0;
                bus_req  <= 1'b0;
                st       <= ST_IDLE;
              end else if (cont) begin
                usize     <= ctrl.size;
                xfer_size <= beat_code(ctrl.size);
                addr_inc  <= step_of(ctrl.size);
              end else begin
                xfer_stb <= 1'b0;
                bus_req  <= 1'b0;
                st       <= ST_GAP;
              end
            end
          end
        end
        ST_GAP:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (cnt_we) cnt <= cnt_data;
    end
  end

endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_req_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter bit HAS_SAMPLE = 1'b1,
  parameter int SYNC_N     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_data,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_data,
  input  logic             req_pin,
  input  logic             periph_req,
  input  logic             bus_ack,
  output logic             xfer_stb,
  output logic [1:0]       xfer_size,
  output logic [2:0]       addr_inc,
  output logic             bus_req,
  output logic             done,
  output logic [7:0]       cfg_q
);

  ctrl_t ctrl;
  logic  clr_en;
  logic  consume;
  logic  req;

  dma_req_ctrl #(.HAS_SAMPLE(HAS_SAMPLE)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_data(cfg_data),
    .clr_en(clr_en), .ctrl(ctrl)
  );

  dma_req_detect #(.SYNC_N(SYNC_N)) u_det (
    .clk(clk), .rst(rst), .pin(req_pin), .periph_req(periph_req),
    .ctrl(ctrl), .consume(consume), .req(req)
  );

  dma_req_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .ctrl(ctrl), .req(req),
    .cnt_we(cnt_we), .cnt_data(cnt_data), .bus_ack(bus_ack),
    .xfer_stb(xfer_stb), .bus_req(bus_req), .xfer_size(xfer_size),
    .addr_inc(addr_inc), .done(done), .clr_en(clr_en), .consume(consume)
  );

  assign cfg_q = ctrl;

endmodule

// File: rtl/dma_req_sva.sv
module dma_req_sva #(
  parameter bit HAS_SAMPLE = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       xfer_stb,
  input logic [1:0] xfer_size,
  input logic [2:0] addr_inc,
  input logic       bus_req,
  input logic       bus_ack,
  input logic       done,
  input logic [7:0] cfg_q
);

  p_stb_owns_bus_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> bus_req);

  p_release_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) && !done |=> !xfer_stb);

  p_beat_hold_r5: assert property (@(posedge clk) disable iff (rst)
    xfer_stb && !bus_ack |=> xfer_stb && $stable(xfer_size) && $stable(addr_inc));

  p_beat_code_r5: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> xfer_size != 2'b11);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !xfer_stb && !bus_req && !cfg_q[0]);

  generate
    if (!HAS_SAMPLE) begin : g_ns
      p_no_sample_field_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_q[7:6] == 2'b00);
    end
  endgenerate

endmodule

bind dma_req_seq dma_req_sva #(.HAS_SAMPLE(HAS_SAMPLE)) u_sva (
  .clk(clk), .rst(rst), .xfer_stb(xfer_stb), .xfer_size(xfer_size),
  .addr_inc(addr_inc), .bus_req(bus_req), .bus_ack(bus_ack),
  .done(done), .cfg_q(cfg_q)
);

// File: tb/tb_dma_req_seq.sv
`timescale 1ns/1ps
module tb_dma_req_seq;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             cfg_we = 0, cnt_we = 0, req_pin = 0, periph_req = 0, bus_ack = 0;
  logic [7:0]       cfg_data = '0;
  logic [CNT_W-1:0] cnt_data = '0;
  logic             xfer_stb, bus_req, done;
  logic [1:0]       xfer_size;
  logic [2:0]       addr_inc;
  logic [7:0]       cfg_q;

  logic             ns_cfg_we = 0, ns_cnt_we = 0, ns_ack = 0;
  logic [7:0]       ns_cfg_data = '0;
  logic [CNT_W-1:0] ns_cnt_data = '0;
  logic             ns_stb, ns_bus, ns_done;
  logic [1:0]       ns_size;
  logic [2:0]       ns_inc;
  logic [7:0]       ns_cfg_q;

  dma_req_seq #(.CNT_W(CNT_W), .HAS_SAMPLE(1'b1)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .cnt_we(cnt_we), .cnt_data(cnt_data), .req_pin(req_pin),
    .periph_req(periph_req), .bus_ack(bus_ack), .xfer_stb(xfer_stb),
    .xfer_size(xfer_size), .addr_inc(addr_inc), .bus_req(bus_req),
    .done(done), .cfg_q(cfg_q)
  );

  dma_req_seq #(.CNT_W(CNT_W), .HAS_SAMPLE(1'b0)) dut_ns (
    .clk(clk), .rst(rst), .cfg_we(ns_cfg_we), .cfg_data(ns_cfg_data),
    .cnt_we(ns_cnt_we), .cnt_data(ns_cnt_data), .req_pin(req_pin),
    .periph_req(1'b0), .bus_ack(ns_ack), .xfer_stb(ns_stb),
    .xfer_size(ns_size), .addr_inc(ns_inc), .bus_req(ns_bus),
    .done(ns_done), .cfg_q(ns_cfg_q)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  int beats, falls, dones, bad_beat;
  bit chk_beat = 0;
  logic [1:0] exp_code;
  logic [2:0] exp_inc;

  // {cfg, count, beats, bus releases, step}; source auto, enable set
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {8'h03, 8'd3, 8'd3,  8'd3, 3'd1},
    {8'h1B, 8'd4, 8'd4,  8'd1, 3'd2},
    {8'h23, 8'd2, 8'd2,  8'd2, 3'd4},
    {8'h33, 8'd2, 8'd8,  8'd2, 3'd4},
    {8'h3B, 8'd3, 8'd12, 8'd1, 3'd4},
    {8'h4B, 8'd1, 8'd1,  8'd1, 3'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_data = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_cnt(input int v);
    @(negedge clk); cnt_we = 1; cnt_data = CNT_W'(v);
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic serve(input int cycles);
    logic prev_bus;
    beats = 0; falls = 0; dones = 0; bad_beat = 0;
    prev_bus = bus_req;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (done) dones++;
      if (prev_bus && !bus_req) falls++;
      prev_bus = bus_req;
      if (xfer_stb) begin
        beats++;
        if (chk_beat && (xfer_size != exp_code || addr_inc != exp_inc)) bad_beat++;
        bus_ack = 1;
      end else begin
        bus_ack = 0;
      end
    end
    @(negedge clk); bus_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    check(cfg_q == 8'h00, "R1 cfg_q", int'(cfg_q), 0);
    check(!xfer_stb && !bus_req && !done, "R1 outputs idle",
          int'({xfer_stb, bus_req, done}), 0);
    check(ns_cfg_q == 8'h00 && !ns_stb, "R1 second instance", int'(ns_cfg_q), 0);

    // R5 R6 R7 R8 R4: table of auto-request runs
    for (int v = 0; v < NV; v++) begin
      logic [7:0] c;
      c = VEC[v][34:27];
      exp_code = (c[5:4] == 2'b11) ? 2'b10 : c[5:4];
      exp_inc  = VEC[v][2:0];
      chk_beat = 1;
      wr_cnt(int'(VEC[v][26:19]));
      wr_cfg(c);
      serve(120);
      chk_beat = 0;
      check(beats == int'(VEC[v][18:11]), "R5 beat total", beats, int'(VEC[v][18:11]));
      check(bad_beat == 0, "R5 size code and step", bad_beat, 0);
      check(falls == int'(VEC[v][10:3]), "R6/R7 bus releases", falls, int'(VEC[v][10:3]));
      check(dones == 1, "R8 single done pulse", dones, 1);
      check(cfg_q[0] == 1'b0, "R8 enable cleared", int'(cfg_q[0]), 0);
    end

    // R10 synchronizer latency, high-level mode
    wr_cnt(1);
    wr_cfg(8'h81);
    @(negedge clk); req_pin = 1;
    @(negedge clk); check(!xfer_stb, "R10 no strobe after 1 edge", int'(xfer_stb), 0);
    @(negedge clk); check(!xfer_stb, "R10 no strobe after 2 edges", int'(xfer_stb), 0);
    @(negedge clk); check(xfer_stb, "R10 strobe after 3 edges", int'(xfer_stb), 1);
    serve(20);
    check(beats == 1 && dones == 1, "R2 high level one unit", beats, 1);

    // R2 low level: pin high means no request
    wr_cnt(2);
    wr_cfg(8'h01);
    serve(30);
    check(beats == 0, "R2 low level idle while pin high", beats, 0);
    req_pin = 0;
    serve(40);
    check(beats == 2 && dones == 1, "R2 low level transfers", beats, 2);

    // R9 rising edge: one unit per edge
    wr_cnt(3);
    wr_cfg(8'hC1);
    serve(20);
    check(beats == 0, "R9 rising no edge", beats, 0);
    req_pin = 1;
    serve(30);
    check(beats == 1, "R9 one unit per rising edge", beats, 1);
    req_pin = 0;
    serve(20);
    check(beats == 0, "R2 rising ignores falling", beats, 0);
    req_pin = 1;
    serve(20);
    check(beats == 1 && dones == 0, "R9 second rising edge", beats, 1);
    check(cfg_q[0] == 1'b1, "R8 enable kept with count left", int'(cfg_q[0]), 1);
    // R2 falling edge mode finishes the last unit
    wr_cfg(8'h41);
    serve(20);
    check(beats == 0, "R9 falling no edge yet", beats, 0);
    req_pin = 0;
    serve(20);
    check(beats == 1 && dones == 1, "R2 falling edge unit and done", beats, 1);

    // R4 peripheral source ignores active-low pin
    wr_cnt(2);
    wr_cfg(8'h05);
    serve(20);
    check(beats == 0, "R4 pin ignored for peripheral source", beats, 0);
    periph_req = 1;
    serve(40);
    check(beats == 2 && dones == 1, "R4 peripheral request transfers", beats, 2);

    // R7 burst withdrawn after two units
    wr_cnt(5);
    wr_cfg(8'h0D);
    beats = 0;
    for (int i = 0; i < 60 && beats < 2; i++) begin
      @(negedge clk);
      if (xfer_stb) begin
        beats++;
        bus_ack = 1;
        if (beats == 2) periph_req = 0;
      end else begin
        bus_ack = 0;
      end
    end
    @(negedge clk); bus_ack = 0;
    check(beats == 2, "R7 burst units before withdraw", beats, 2);
    serve(20);
    check(beats == 0 && !bus_req, "R7 burst stops on withdraw", beats, 0);
    periph_req = 1;
    serve(40);
    check(beats == 3 && falls == 1 && dones == 1, "R7 burst resumes remaining count", beats, 3);
    periph_req = 0;

    // R3 instance without sampling field: rising mode write reads 00, low level used
    @(negedge clk); ns_cnt_we = 1; ns_cnt_data = 1;
    @(negedge clk); ns_cnt_we = 0; ns_cfg_we = 1; ns_cfg_data = 8'hC1;
    @(negedge clk); ns_cfg_we = 0;
    check(ns_cfg_q == 8'h01, "R3 sampling field reads zero", int'(ns_cfg_q), 1);
    beats = 0; dones = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (ns_done) dones++;
      if (ns_stb) begin beats++; ns_ack = 1; end
      else ns_ack = 0;
    end
    @(negedge clk); ns_ack = 0;
    check(beats == 1 && dones == 1, "R3 low level without edge", beats, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule